// File: doc/BRIEF.md
# Enable-Gated Counting Stream Source

This block produces packets of 32-bit words on an AXI4-Stream master port, meant to feed a DMA engine that writes them into memory. Each word is one step of a running counter, so the receiving software can check a transfer end to end. The number of words per packet comes from a length register. The final word of each packet carries tlast.

Software controls the block through a small AXI4-Lite slave. The register at offset 0x0 holds the packet length. The register at offset 0x4 holds two enable bits. The stream state machine has two states, `ST_IDLE` and `ST_SEND`. It stays in `ST_IDLE` with tvalid low until both enable bits are set. A downstream FIFO that raises tready straight after reset therefore cannot capture any word before software has set up the DMA. The intended order for software is: write the length, clear and then set the arm bit, and finally set the stream bit.

The state machine has four named transitions. `START` goes from `ST_IDLE` to `ST_SEND` when the run condition is true; it loads the packet length and raises tvalid. `NEXT` stays in `ST_SEND` after an accepted beat that is not the last. `RESTART` stays in `ST_SEND` when the last beat is accepted and the run condition still holds; it reloads the length for a new packet. `DRAIN` goes from `ST_SEND` back to `ST_IDLE` when the last beat is accepted and the run condition has been withdrawn.

Top module: `axis_count_source`

## Requirements
- R1: After reset, tvalid is low, the length register reads 8 and the control register reads 0.
- R2: tvalid stays low until control bit 1 (arm) and control bit 0 (stream) are both 1. It stays low even if tready is held high from reset, and even if only one of the two bits is set.
- R3: The first word after reset is 1. Each accepted beat increments the word by 1, and the count continues across packet boundaries.
- R4: A packet has as many beats as the length register held when the packet started, and tlast is high only on its final beat. A length of 0 behaves as a length of 1.
- R5: While tvalid is high and tready is low, tvalid, tdata and tlast hold their values. A beat is transferred only on a cycle where tvalid and tready are both high.
- R6: If either enable bit is cleared during a packet, the packet still completes through its tlast beat. tvalid then goes low and the block returns to idle.
- R7: Every write and read returns an OKAY response (code 0). Offset 0x0 reads back the length, zero-extended. Offset 0x4 reads back arm in bit 1 and stream in bit 0, with all other bits 0. Reads from any other offset return 0, and writes to other offsets change nothing.
- R8: A write to the length register changes only the byte lanes whose write strobe bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | 4 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 4 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| m_tdata | output | 32 | Stream payload word |
| m_tvalid | output | 1 | Stream word valid |
| m_tready | input | 1 | Stream sink ready |
| m_tlast | output | 1 | Final word of the packet |

## Verification
The hardest situation to reach is a disable that arrives in the middle of a packet. With a sink that is always ready, the packet can end before a register write completes, so the write never lands inside the packet. The stimulus avoids this by keeping tready low while the disable write is in flight. The write is issued after the final packet's first word is already on the bus. Beats are then released one at a time, with a chosen number of stall cycles before each one. This exercises the drain through tlast and the hold-while-stalled rule together, and back-to-back packets under the `RESTART` transition are covered as well.

// File: rtl/acs_pkg.sv
package acs_pkg;
    localparam int LITE_W      = 32;
    localparam int LITE_BYTES  = LITE_W / 8;
    localparam int CTRL_STREAM = 0;
    localparam int CTRL_ARM    = 1;
    localparam logic [1:0] RESP_OKAY = 2'b00;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_SEND
    } stream_state_e;

    typedef enum logic [1:0] {
        SEL_LEN,
        SEL_CTRL,
        SEL_NONE
    } reg_sel_e;
endpackage

// File: rtl/acs_regs.sv
module acs_regs
    import acs_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int LEN_W   = 16,
    parameter int DEF_LEN = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     awaddr,
    input  logic                  awvalid,
    output logic                  awready,
    input  logic [LITE_W-1:0]     wdata,
    input  logic [LITE_BYTES-1:0] wstrb,
    input  logic                  wvalid,
    output logic                  wready,
    output logic [1:0]            bresp,
    output logic                  bvalid,
    input  logic                  bready,
    input  logic [ADDR_W-1:0]     araddr,
    input  logic                  arvalid,
    output logic                  arready,
    output logic [LITE_W-1:0]     rdata,
    output logic [1:0]            rresp,
    output logic                  rvalid,
    input  logic                  rready,
    output logic [LEN_W-1:0]      len_o,
    output logic                  run_o
);
    logic [LEN_W-1:0]  len_q;
    logic              arm_q;
    logic              stream_q;
    logic              wr_fire;
    logic              rd_fire;
    reg_sel_e          wr_sel;
    reg_sel_e          rd_sel;
    logic [LITE_W-1:0] rd_word;
    logic              unused_bits;

    function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
        if (a[1:0] != 2'b00)
            return SEL_NONE;
        else if (a[ADDR_W-1:2] == '0)
            return SEL_LEN;
        else if (a[ADDR_W-1:2] == (ADDR_W-2)'(1))
            return SEL_CTRL;
        else
            return SEL_NONE;
    endfunction

    assign unused_bits = ^{wdata, wstrb};

    assign wr_fire = awvalid && wvalid && !bvalid;
    assign awready = wr_fire;
    assign wready  = wr_fire;
    assign bresp   = RESP_OKAY;
    assign wr_sel  = decode(awaddr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q    <= LEN_W'(DEF_LEN);
            arm_q    <= 1'b0;
            stream_q <= 1'b0;
            bvalid   <= 1'b0;
        end else begin
            if (wr_fire) begin
                bvalid <= 1'b1;
                unique case (wr_sel)
                    SEL_LEN: begin
                        for (int i = 0; i < LEN_W; i++) begin
                            if (wstrb[i/8])
                                len_q[i] <= wdata[i];
                        end
                    end
                    SEL_CTRL: begin
                        if (wstrb[0]) begin
                            arm_q    <= wdata[CTRL_ARM];
                            stream_q <= wdata[CTRL_STREAM];
                        end
                    end
                    default: ;
                endcase
            end else if (bvalid && bready) begin
                bvalid <= 1'b0;
            end
        end
    end

    assign rd_fire = arvalid && !rvalid;
    assign arready = !rvalid;
    assign rresp   = RESP_OKAY;
    assign rd_sel  = decode(araddr);

    always_comb begin
        rd_word = '0;
        unique case (rd_sel)
            SEL_LEN:  rd_word = LITE_W'(len_q);
            SEL_CTRL: begin
                rd_word[CTRL_ARM]    = arm_q;
                rd_word[CTRL_STREAM] = stream_q;
            end
            default:  rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else if (rd_fire) begin
            rvalid <= 1'b1;
            rdata  <= rd_word;
        end else if (rvalid && rready) begin
            rvalid <= 1'b0;
        end
    end

    assign len_o = len_q;
    assign run_o = arm_q && stream_q;
endmodule

// File: rtl/acs_stream.sv
module acs_stream
    import acs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [LEN_W-1:0]  len,
    input  logic              tready,
    output logic              tvalid,
    output logic [DATA_W-1:0] tdata,
    output logic              tlast
);
    stream_state_e     state_q;
    stream_state_e     state_d;
    logic [LEN_W-1:0]  beat_q;
    logic [LEN_W-1:0]  last_q;
    logic [DATA_W-1:0] data_q;
    logic              accept;
    logic              at_last;
    logic              load;

    assign accept  = tvalid && tready;
    assign at_last = (beat_q == last_q);
    assign load    = ((state_q == ST_IDLE) && run) || (accept && at_last && run);

    // next state: START, NEXT, RESTART, DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (run) state_d = ST_SEND;
            ST_SEND: if (accept && at_last && !run) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
            last_q <= '0;
            data_q <= DATA_W'(1);
        end else begin
            if (load)
                last_q <= (len == '0) ? '0 : len - LEN_W'(1);
            if (accept) begin
                beat_q <= at_last ? '0 : beat_q + LEN_W'(1);
                data_q <= data_q + DATA_W'(1);
            end
        end
    end

    always_comb begin
        tvalid = 1'b0;
        tlast  = 1'b0;
        tdata  = data_q;
        unique case (state_q)
            ST_IDLE: tvalid = 1'b0;
            ST_SEND: begin
                tvalid = 1'b1;
                tlast  = at_last;
            end
            default: tvalid = 1'b0;
        endcase
    end
endmodule

// File: rtl/axis_count_source.sv
module axis_count_source
    import acs_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int LEN_W   = 16,
    parameter int DEF_LEN = 8,
    parameter int DATA_W  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     s_awaddr,
    input  logic                  s_awvalid,
    output logic                  s_awready,
    input  logic [LITE_W-1:0]     s_wdata,
    input  logic [LITE_BYTES-1:0] s_wstrb,
    input  logic                  s_wvalid,
    output logic                  s_wready,
    output logic [1:0]            s_bresp,
    output logic                  s_bvalid,
    input  logic                  s_bready,
    input  logic [ADDR_W-1:0]     s_araddr,
    input  logic                  s_arvalid,
    output logic                  s_arready,
    output logic [LITE_W-1:0]     s_rdata,
    output logic [1:0]            s_rresp,
    output logic                  s_rvalid,
    input  logic                  s_rready,
    output logic [DATA_W-1:0]     m_tdata,
    output logic                  m_tvalid,
    input  logic                  m_tready,
    output logic                  m_tlast
);
    logic [LEN_W-1:0] len_w;
    logic             run_w;

    acs_regs #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .DEF_LEN(DEF_LEN)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .awaddr (s_awaddr),
        .awvalid(s_awvalid),
        .awready(s_awready),
        .wdata  (s_wdata),
        .wstrb  (s_wstrb),
        .wvalid (s_wvalid),
        .wready (s_wready),
        .bresp  (s_bresp),
        .bvalid (s_bvalid),
        .bready (s_bready),
        .araddr (s_araddr),
        .arvalid(s_arvalid),
        .arready(s_arready),
        .rdata  (s_rdata),
        .rresp  (s_rresp),
        .rvalid (s_rvalid),
        .rready (s_rready),
        .len_o  (len_w),
        .run_o  (run_w)
    );

    acs_stream #(
        .DATA_W(DATA_W),
        .LEN_W (LEN_W)
    ) u_stream (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_w),
        .len   (len_w),
        .tready(m_tready),
        .tvalid(m_tvalid),
        .tdata (m_tdata),
        .tlast (m_tlast)
    );
endmodule

// File: rtl/acs_checker.sv
module acs_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              tvalid,
    input logic              tready,
    input logic              tlast,
    input logic [DATA_W-1:0] tdata,
    input logic              bvalid,
    input logic [1:0]        bresp,
    input logic              rvalid,
    input logic [1:0]        rresp
);
    assert_start_needs_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tvalid) |-> $past(run));

    assert_count_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tvalid && tready) && tvalid) |-> (tdata == $past(tdata) + DATA_W'(1)));

    assert_hold_on_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tvalid && !tready) |=> (tvalid && $stable(tdata) && $stable(tlast)));

    assert_no_abandon_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tvalid && !tlast) |=> tvalid);

    assert_drain_to_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tvalid && tready && tlast && !run) |=> !tvalid);

    assert_write_okay_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid |-> (bresp == 2'b00));

    assert_read_okay_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> (rresp == 2'b00));
endmodule

bind axis_count_source acs_checker #(.DATA_W(DATA_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_w),
    .tvalid(m_tvalid),
    .tready(m_tready),
    .tlast (m_tlast),
    .tdata (m_tdata),
    .bvalid(s_bvalid),
    .bresp (s_bresp),
    .rvalid(s_rvalid),
    .rresp (s_rresp)
);

// File: tb/axis_count_source_bench.sv
module axis_count_source_bench;
    localparam int VEC_N = 5;
    localparam int T_LEN   [VEC_N] = '{8, 3, 1, 0, 5};
    localparam int T_PKTS  [VEC_N] = '{1, 2, 3, 2, 1};
    localparam int T_STALL [VEC_N] = '{0, 2, 0, 1, 3};
    localparam int T_LASTW [VEC_N] = '{8, 14, 17, 19, 24};

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  s_awaddr, s_araddr;
    logic        s_awvalid, s_awready, s_wvalid, s_wready;
    logic [31:0] s_wdata, s_rdata;
    logic [3:0]  s_wstrb;
    logic [1:0]  s_bresp, s_rresp;
    logic        s_bvalid, s_bready, s_arvalid, s_arready, s_rvalid, s_rready;
    logic [31:0] m_tdata;
    logic        m_tvalid, m_tready, m_tlast;

    int          checks = 0;
    int          errors = 0;
    logic [31:0] exp_data;
    logic [31:0] rd;

    always #4 clk = ~clk;

    axis_count_source u_axis_count_source (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic lite_write(input logic [3:0] addr, input logic [31:0] data, input logic [3:0] strb);
        @(negedge clk);
        s_awaddr = addr; s_awvalid = 1'b1;
        s_wdata = data; s_wstrb = strb; s_wvalid = 1'b1; s_bready = 1'b1;
        while (!s_awready) @(negedge clk);
        @(negedge clk);
        s_awvalid = 1'b0; s_wvalid = 1'b0;
        chk(s_bvalid && s_bresp == 2'b00, "R7 write response", {29'b0, s_bvalid, s_bresp}, 32'h4);
        @(negedge clk);
        s_bready = 1'b0;
    endtask

    task automatic lite_read(input logic [3:0] addr, output logic [31:0] data);
        @(negedge clk);
        s_araddr = addr; s_arvalid = 1'b1; s_rready = 1'b0;
        while (!s_arready) @(negedge clk);
        @(negedge clk);
        s_arvalid = 1'b0;
        data = s_rdata;
        chk(s_rvalid && s_rresp == 2'b00, "R7 read response", {29'b0, s_rvalid, s_rresp}, 32'h4);
        s_rready = 1'b1;
        @(negedge clk);
        s_rready = 1'b0;
    endtask

    task automatic hold_low(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk(!m_tvalid, req, {31'b0, m_tvalid}, 32'h0);
        end
    endtask

    task automatic take_beat(input int stall, input bit exp_last);
        while (!m_tvalid) @(negedge clk);
        chk(m_tdata == exp_data, "R3 payload word", m_tdata, exp_data);
        chk(m_tlast == exp_last, "R4 tlast position", {31'b0, m_tlast}, {31'b0, exp_last});
        for (int k = 0; k < stall; k++) begin
            @(negedge clk);
            chk(m_tvalid && m_tdata == exp_data && m_tlast == exp_last,
                "R5 hold while stalled", m_tdata, exp_data);
        end
        m_tready = 1'b1;
        @(negedge clk);
        m_tready = 1'b0;
        exp_data++;
    endtask

    task automatic run_entry(input int len, input int pkts, input int stall);
        int eff;
        eff = (len == 0) ? 1 : len;
        lite_write(4'h0, 32'(len), 4'hF);
        lite_write(4'h4, 32'h0, 4'hF);
        lite_write(4'h4, 32'h2, 4'hF);
        hold_low(4, "R2 arm bit alone");
        lite_write(4'h4, 32'h3, 4'hF);
        for (int p = 0; p < pkts; p++) begin
            if (p == pkts - 1) begin
                while (!m_tvalid) @(negedge clk);
                lite_write(4'h4, 32'h2, 4'hF);  // R6: disable inside the last packet
            end
            for (int b = 0; b < eff; b++)
                take_beat(stall, b == eff - 1);
        end
        hold_low(5, "R6 idle after drain");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        s_awaddr = '0; s_awvalid = 1'b0; s_wdata = '0; s_wstrb = '0; s_wvalid = 1'b0;
        s_bready = 1'b0; s_araddr = '0; s_arvalid = 1'b0; s_rready = 1'b0;
        m_tready = 1'b1;
        exp_data = 32'd1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        chk(!m_tvalid, "R1 tvalid low after reset", {31'b0, m_tvalid}, 32'h0);
        lite_read(4'h0, rd);
        chk(rd == 32'd8, "R1 default length", rd, 32'd8);
        lite_read(4'h4, rd);
        chk(rd == 32'd0, "R1 control cleared", rd, 32'd0);
        hold_low(20, "R2 no leak with ready from reset");
        m_tready = 1'b0;

        for (int i = 0; i < VEC_N; i++) begin
            run_entry(T_LEN[i], T_PKTS[i], T_STALL[i]);
            chk(exp_data - 32'd1 == 32'(T_LASTW[i]), "R3 running count across packets",
                exp_data - 32'd1, 32'(T_LASTW[i]));
        end

        // R8: byte-lane strobes on the length register
        lite_write(4'h0, 32'h0000_12CD, 4'b0001);
        lite_read(4'h0, rd);
        chk(rd == 32'h0000_00CD, "R8 low lane only", rd, 32'h0000_00CD);
        lite_write(4'h0, 32'h0000_3477, 4'b0010);
        lite_read(4'h0, rd);
        chk(rd == 32'h0000_34CD, "R8 second lane only", rd, 32'h0000_34CD);

        // R7: unmapped offset
        lite_write(4'h8, 32'hFFFF_FFFF, 4'hF);
        lite_read(4'h8, rd);
        chk(rd == 32'h0, "R7 unmapped read zero", rd, 32'h0);
        lite_read(4'h0, rd);
        chk(rd == 32'h0000_34CD, "R7 unmapped write ignored", rd, 32'h0000_34CD);

        // R7/R2: upper control bits read as zero, stream bit alone does not start
        lite_write(4'h4, 32'hFFFF_FFFC, 4'hF);
        lite_read(4'h4, rd);
        chk(rd == 32'h0, "R7 control upper bits", rd, 32'h0);
        lite_write(4'h4, 32'h1, 4'hF);
        lite_read(4'h4, rd);
        chk(rd == 32'h1, "R7 control readback", rd, 32'h1);
        hold_low(6, "R2 stream bit alone");
        lite_write(4'h4, 32'h0, 4'hF);

        // R1/R3: second reset restarts the count at 1
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_data = 32'd1;
        chk(!m_tvalid, "R1 tvalid low after second reset", {31'b0, m_tvalid}, 32'h0);
        lite_read(4'h0, rd);
        chk(rd == 32'd8, "R1 length restored", rd, 32'd8);
        lite_read(4'h4, rd);
        chk(rd == 32'd0, "R1 control restored", rd, 32'd0);
        run_entry(8, 1, 1);
        chk(exp_data == 32'd9, "R3 restart after reset", exp_data, 32'd9);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule